// File: doc/BRIEF.md
# Skewed Sixteen-Bank Transpose Buffer

This block turns data that arrives one sector at a time into data that leaves one word index at a time. A write carries a 512-bit row, which is sixteen consecutive 32-bit words of one sector, and a sector tag from 0 to 15. A read names a word index and returns that word from all sixteen sectors at once, one sector per output lane. A hashing stage can then work on sixteen sectors in parallel, with one lane per sector.

The storage is split into sixteen single-port banks. Each row is stored with a diagonal skew: word j of sector q goes to bank (j + q) mod 16. Because of this skew, a row write touches every bank exactly once, and a column read does the same. Every access finishes in a single cycle with no bank conflict. A crossbar on the read path undoes the skew, so lane q always carries sector q.

The buffer alternates between a fill phase and a drain phase. It accepts rows until all sixteen sectors have been written. It then accepts reads until all sixteen word indices have been read, and then it returns to filling. Each 512-byte sector passes through the buffer as eight such 512-bit spans in eight successive fills.

Top module: `skew_xpose_buf`

## Requirements
- R1: After reset, `wr_ready` is 1, `rd_ready` is 0 and `rd_data_valid` is 0.
- R2: A write presented while `wr_ready` is 0 has no effect: the stored data and the phase are unchanged.
- R3: The buffer switches to the drain phase (`wr_ready` 0, `rd_ready` 1) on the write that completes the set of all sixteen distinct sector tags. A repeated tag does not count towards the set, and the later row for that tag replaces the earlier one.
- R4: A read of word index j returns, in lane q (`rd_lanes[q*32 +: 32]`), word j of sector q, where word j of a row is `wr_row[j*32 +: 32]`.
- R5: Read data and `rd_data_valid` = 1 appear exactly one cycle after the cycle in which a read is accepted (`rd_valid` and `rd_ready` both 1).
- R6: A read presented while `rd_ready` is 0 is ignored, and `rd_data_valid` stays 0 in the following cycle.
- R7: The buffer returns to the fill phase on the read that completes the set of all sixteen distinct word indices. A repeated index does not count towards the set and returns the same data again.
- R8: `wr_ready` and `rd_ready` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Row write request |
| wr_ready | output | 1 | High in the fill phase; a write is taken when it and wr_valid are both high |
| wr_sector | input | 4 | Sector tag of the row |
| wr_row | input | 512 | Sixteen words of one sector, word j in bits j*32 +: 32 |
| rd_valid | input | 1 | Column read request |
| rd_ready | output | 1 | High in the drain phase; a read is taken when it and rd_valid are both high |
| rd_word | input | 4 | Word index to read |
| rd_data_valid | output | 1 | rd_lanes holds the data for the read taken in the previous cycle |
| rd_lanes | output | 512 | Sixteen words, lane q (sector q) in bits q*32 +: 32 |

## Verification
The bound checker checks the handshake on every cycle: the two ready flags are exclusive, every accepted read is followed by valid data one cycle later, no valid data appears without an accepted read, and a phase never ends in a cycle with no request. Data correctness can only be shown by the bench scenarios. A scoreboard compares every lane after writes in different sector orders, a duplicated sector tag, a rejected write during drain, repeated and scrambled read indices, and a read attempted while filling.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;

    localparam int XB_LANES  = 16;
    localparam int XB_WORD_W = 32;

    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

    // Request seen by the bank array in one cycle
    typedef struct packed {
        logic en;
        logic we;
    } bank_op_t;

    function automatic int wrap_add(input int a, input int b, input int n);
        return (a + b) % n;
    endfunction

    function automatic int wrap_sub(input int a, input int b, input int n);
        return (a - b + n) % n;
    endfunction

endpackage

// File: rtl/xbuf_ctrl.sv
module xbuf_ctrl
    import xbuf_pkg::*;
#(
    parameter int LANES = XB_LANES,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] wr_sector,
    input  logic             rd_valid,
    input  logic [IDX_W-1:0] rd_word,
    output logic             wr_fire,
    output logic             rd_fire,
    output logic             wr_ready,
    output logic             rd_ready,
    output logic             rd_data_valid,
    output logic [IDX_W-1:0] rd_word_q
);

    phase_e           phase;
    logic [LANES-1:0] sect_seen;
    logic [LANES-1:0] word_seen;
    logic [LANES-1:0] sect_next;
    logic [LANES-1:0] word_next;

    assign wr_ready = (phase == PH_FILL);
    assign rd_ready = (phase == PH_DRAIN);
    assign wr_fire  = wr_valid && wr_ready;
    assign rd_fire  = rd_valid && rd_ready;

    always_comb begin
        sect_next = sect_seen | (LANES'(1) << wr_sector);
        word_next = word_seen | (LANES'(1) << rd_word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase         <= PH_FILL;
            sect_seen     <= '0;
            word_seen     <= '0;
            rd_data_valid <= 1'b0;
            rd_word_q     <= '0;
        end else begin
            rd_data_valid <= rd_fire;
            if (rd_fire) begin
                rd_word_q <= rd_word;
            end
            if (wr_fire) begin
                if (&sect_next) begin
                    phase     <= PH_DRAIN;
                    sect_seen <= '0;
                end else begin
                    sect_seen <= sect_next;
                end
            end
            if (rd_fire) begin
                if (&word_next) begin
                    phase     <= PH_FILL;
                    word_seen <= '0;
                end else begin
                    word_seen <= word_next;
                end
            end
        end
    end

endmodule

// File: rtl/xbuf_skew_in.sv
module xbuf_skew_in
    import xbuf_pkg::*;
#(
    parameter int LANES  = XB_LANES,
    parameter int WORD_W = XB_WORD_W,
    localparam int IDX_W = $clog2(LANES),
    localparam int ROW_W = LANES * WORD_W
) (
    input  logic [ROW_W-1:0] row,
    input  logic [IDX_W-1:0] sector,
    output logic [ROW_W-1:0] bank_wdata
);

    // Bank b receives the row word whose index j satisfies (j + sector) mod LANES == b
    always_comb begin
        for (int b = 0; b < LANES; b++) begin
            bank_wdata[b*WORD_W +: WORD_W] =
                row[wrap_sub(b, int'(sector), LANES)*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/xbuf_skew_out.sv
module xbuf_skew_out
    import xbuf_pkg::*;
#(
    parameter int LANES  = XB_LANES,
    parameter int WORD_W = XB_WORD_W,
    localparam int IDX_W = $clog2(LANES),
    localparam int ROW_W = LANES * WORD_W
) (
    input  logic [ROW_W-1:0] bank_rdata,
    input  logic [IDX_W-1:0] word_idx,
    output logic [ROW_W-1:0] lanes
);

    // Lane q takes the bank holding word word_idx of sector q
    always_comb begin
        for (int q = 0; q < LANES; q++) begin
            lanes[q*WORD_W +: WORD_W] =
                bank_rdata[wrap_add(int'(word_idx), q, LANES)*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/xbuf_bank.sv
module xbuf_bank #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/skew_xpose_buf.sv
module skew_xpose_buf
    import xbuf_pkg::*;
#(
    parameter int LANES  = XB_LANES,
    parameter int WORD_W = XB_WORD_W,
    localparam int IDX_W = $clog2(LANES),
    localparam int ROW_W = LANES * WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [IDX_W-1:0] wr_sector,
    input  logic [ROW_W-1:0] wr_row,
    input  logic             rd_valid,
    output logic             rd_ready,
    input  logic [IDX_W-1:0] rd_word,
    output logic             rd_data_valid,
    output logic [ROW_W-1:0] rd_lanes
);

    logic             wr_fire;
    logic             rd_fire;
    logic [IDX_W-1:0] rd_word_q;
    logic [ROW_W-1:0] bank_wdata;
    logic [ROW_W-1:0] bank_rdata;
    bank_op_t         op;

    xbuf_ctrl #(.LANES(LANES)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .wr_valid      (wr_valid),
        .wr_sector     (wr_sector),
        .rd_valid      (rd_valid),
        .rd_word       (rd_word),
        .wr_fire       (wr_fire),
        .rd_fire       (rd_fire),
        .wr_ready      (wr_ready),
        .rd_ready      (rd_ready),
        .rd_data_valid (rd_data_valid),
        .rd_word_q     (rd_word_q)
    );

    xbuf_skew_in #(.LANES(LANES), .WORD_W(WORD_W)) u_skew_in (
        .row        (wr_row),
        .sector     (wr_sector),
        .bank_wdata (bank_wdata)
    );

    always_comb begin
        op.en = wr_fire || rd_fire;
        op.we = wr_fire;
    end

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        logic [IDX_W-1:0] addr;

        // Write: row slot is the sector tag. Read: bank b holds word rd_word of sector (b - rd_word).
        always_comb begin
            if (op.we) begin
                addr = wr_sector;
            end else begin
                addr = IDX_W'(wrap_sub(b, int'(rd_word), LANES));
            end
        end

        xbuf_bank #(.DEPTH(LANES), .WORD_W(WORD_W)) u_bank (
            .clk   (clk),
            .en    (op.en),
            .we    (op.we),
            .addr  (addr),
            .wdata (bank_wdata[b*WORD_W +: WORD_W]),
            .rdata (bank_rdata[b*WORD_W +: WORD_W])
        );
    end

    xbuf_skew_out #(.LANES(LANES), .WORD_W(WORD_W)) u_skew_out (
        .bank_rdata (bank_rdata),
        .word_idx   (rd_word_q),
        .lanes      (rd_lanes)
    );

endmodule

// File: rtl/xbuf_checker.sv
module xbuf_checker (
    input logic clk,
    input logic rst,
    input logic wr_valid,
    input logic wr_ready,
    input logic rd_valid,
    input logic rd_ready,
    input logic rd_data_valid
);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    // R1: first cycle after reset shows the fill phase
    always_ff @(posedge clk) begin
        if (rst_q === 1'b1 && rst === 1'b0) begin
            a_r1_reset_state: assert (wr_ready && !rd_ready && !rd_data_valid)
                else $error("R1 reset state wrong");
        end
    end

    a_r8_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(wr_ready && rd_ready));

    a_r5_data_follows_read: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready) |=> rd_data_valid);

    a_r6_no_spurious_data: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && rd_ready) |=> !rd_data_valid);

    a_r3_fill_needs_write: assert property (@(posedge clk) disable iff (rst)
        (wr_ready && !wr_valid) |=> wr_ready);

    a_r7_drain_needs_read: assert property (@(posedge clk) disable iff (rst)
        (rd_ready && !rd_valid) |=> rd_ready);

endmodule

bind skew_xpose_buf xbuf_checker u_xbuf_checker (
    .clk           (clk),
    .rst           (rst),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .rd_data_valid (rd_data_valid)
);

// File: tb/test_skew_xpose_buf.sv
`timescale 1ns/1ps
module test_skew_xpose_buf;

    localparam int L  = 16;
    localparam int W  = 32;
    localparam int RW = L * W;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_valid;
    logic          wr_ready;
    logic [3:0]    wr_sector;
    logic [RW-1:0] wr_row;
    logic          rd_valid;
    logic          rd_ready;
    logic [3:0]    rd_word;
    logic          rd_data_valid;
    logic [RW-1:0] rd_lanes;

    skew_xpose_buf i_skew_xpose_buf (
        .clk           (clk),
        .rst           (rst),
        .wr_valid      (wr_valid),
        .wr_ready      (wr_ready),
        .wr_sector     (wr_sector),
        .wr_row        (wr_row),
        .rd_valid      (rd_valid),
        .rd_ready      (rd_ready),
        .rd_word       (rd_word),
        .rd_data_valid (rd_data_valid),
        .rd_lanes      (rd_lanes)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic [W-1:0]  mdl [L][L];   // mdl[sector][word]
    bit            b_fill;
    logic [L-1:0]  b_sect_seen;
    logic [L-1:0]  b_word_seen;
    logic [RW-1:0] exp_q [$];

    task automatic check(input bit ok, input string req, input logic [RW-1:0] act,
                         input logic [RW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(int q, int j, int k);
        return (32'(k) << 24) | (32'(q) << 16) | (32'(j) << 8) | 32'((q * 5 + j * 3 + k) & 8'hff);
    endfunction

    // Enter at posedge+1, leave at posedge+1
    task automatic write_row(input int q, input int k);
        wr_valid  = 1'b1;
        wr_sector = 4'(q);
        for (int j = 0; j < L; j++) wr_row[j*W +: W] = pat(q, j, k);
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
        if (b_fill) begin
            for (int j = 0; j < L; j++) mdl[q][j] = pat(q, j, k);
            b_sect_seen[q] = 1'b1;
            if (&b_sect_seen) begin
                b_fill      = 1'b0;
                b_sect_seen = '0;
            end
        end
    endtask

    task automatic read_col(input int j);
        logic [RW-1:0] e;
        rd_valid = 1'b1;
        rd_word  = 4'(j);
        @(posedge clk);
        #1;
        rd_valid = 1'b0;
        if (!b_fill) begin
            for (int q = 0; q < L; q++) e[q*W +: W] = mdl[q][j];
            exp_q.push_back(e);
            b_word_seen[j] = 1'b1;
            if (&b_word_seen) begin
                b_fill      = 1'b1;
                b_word_seen = '0;
            end
        end
    endtask

    task automatic realign;
        @(posedge clk);
        #1;
    endtask

    // Monitor: scoreboard pop at negedge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (exp_q.size() > 0) begin
                logic [RW-1:0] e;
                e = exp_q.pop_front();
                check(rd_data_valid === 1'b1, "R5 data valid one cycle after read",
                      RW'(rd_data_valid), RW'(1));
                check(rd_lanes === e, "R4 lane data", rd_lanes, e);
            end else if (rd_data_valid !== 1'b0) begin
                check(1'b0, "R6 unexpected read data", RW'(rd_data_valid), RW'(0));
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        check(1'b0, "watchdog expired", '0, '0);
        finish_run();
    end

    initial begin
        rst = 1'b1; wr_valid = 1'b0; wr_sector = '0; wr_row = '0;
        rd_valid = 1'b0; rd_word = '0;
        b_fill = 1'b1; b_sect_seen = '0; b_word_seen = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(wr_ready === 1'b1, "R1 wr_ready after reset", RW'(wr_ready), RW'(1));
        check(rd_ready === 1'b0, "R1 rd_ready after reset", RW'(rd_ready), RW'(0));
        check(rd_data_valid === 1'b0, "R1 rd_data_valid after reset", RW'(rd_data_valid), RW'(0));
        realign();

        // R6: read while filling is ignored
        read_col(2);
        @(negedge clk);
        check(rd_data_valid === 1'b0, "R6 read ignored while filling", RW'(rd_data_valid), RW'(0));
        realign();

        // R3: duplicate tag, later row wins; 15 distinct tags do not fill
        write_row(3, 99);
        for (int q = 0; q < 15; q++) write_row(q, 1);
        @(negedge clk);
        check(wr_ready === 1'b1 && rd_ready === 1'b0, "R3 not full after 15 distinct",
              RW'({wr_ready, rd_ready}), RW'(2'b10));
        realign();
        write_row(15, 1);
        @(negedge clk);
        check(rd_ready === 1'b1 && wr_ready === 1'b0, "R3 full after 16 distinct",
              RW'({wr_ready, rd_ready}), RW'(2'b01));
        realign();

        // R2: write during drain is ignored (model unchanged, read back below)
        write_row(0, 77);
        write_row(9, 77);
        @(negedge clk);
        check(rd_ready === 1'b1, "R2 phase unchanged by rejected write", RW'(rd_ready), RW'(1));
        realign();

        // R7: repeated index does not count
        read_col(5);
        read_col(5);
        for (int j = 0; j < 15; j++) if (j != 5) read_col(j);
        @(negedge clk);
        check(rd_ready === 1'b1, "R7 still draining after 15 distinct", RW'(rd_ready), RW'(1));
        realign();
        read_col(15);
        @(negedge clk);
        check(wr_ready === 1'b1 && rd_ready === 1'b0, "R7 back to fill after 16 distinct",
              RW'({wr_ready, rd_ready}), RW'(2'b10));
        realign();

        // Second pass: reverse sector order, scrambled read order, back to back
        for (int q = L - 1; q >= 0; q--) write_row(q, 2);
        for (int i = 0; i < L; i++) read_col((7 * i + 3) % L);

        // Third pass: interleaved idle cycles and a read attempt during fill
        for (int q = 0; q < L; q++) begin
            write_row((q * 5 + 1) % L, 3);
            if (q == 8) read_col(4);
            realign();
        end
        for (int i = 0; i < L; i++) begin
            read_col(L - 1 - i);
            if (i % 3 == 0) realign();
        end

        repeat (3) realign();
        check(exp_q.size() == 0, "R5 all expected reads delivered", RW'(exp_q.size()), RW'(0));
        finish_run();
    end

endmodule